// File: doc/BRIEF.md
# Switch Driver Operating Mode Controller

This block keeps track of the operating mode of a multi-channel load switch driver. It has four modes: Sleep, Idle, Active and Limp Home. On every clock edge it reads the wake pin, the direct channel input pins, the channel enable bits, an activate bit and two PWM-generator enable bits, and from these it picks the next mode. The current mode, combined with two supply undervoltage flags, then sets four things: whether the register file is held in reset, whether the serial port may talk, whether register writes are accepted, and whether each channel may take its drive from serial-port bits as well as from the input pins.

A wake-up from Sleep, Idle or Limp Home into Active does not happen at once. A programmable wake counter has to run out first, and channel turn-on stays blocked until it does. While the counter runs, the block reports Idle. A low wake pin always overrides this: the block goes to Limp Home if any input pin is high, and to Sleep otherwise.

The transitions have these names:
- FALL_ASLEEP: any mode goes to Sleep.
- ENTER_LIMP: any mode goes to Limp Home.
- SETTLE_IDLE: any mode goes to Idle when there is no request.
- WAKE_WAIT: Sleep, Idle or Limp Home goes to Idle while the counter runs.
- WAKE_DONE: the block goes to Active when the counter expires.
- STAY_ACTIVE: Active remains Active.

Top module: `drv_mode_ctrl`

## Requirements
- R1: With the wake pin low and every input pin low, the mode one edge later is Sleep (code 0). The mode codes are Sleep=0, Idle=1, Active=2 and Limp Home=3.
- R2: With the wake pin low and any input pin high, the mode one edge later is Limp Home (code 3).
- R3: With the wake pin high and no request, the mode one edge later is Idle (code 1). A request means any input pin, any channel enable, the activate bit or either PWM enable being high.
- R4: With the wake pin high and a request held continuously, and starting from any mode other than Active, the mode is Idle for `wake_dly` edges and becomes Active on edge `wake_dly`+1. If the request drops, the count starts again from zero.
- R5: Active remains Active for as long as the wake pin is high and a request is present.
- R6: `regs_rst` is high exactly when the mode is Sleep or the logic-supply undervoltage flag is set.
- R7: `spi_ok` is high exactly when the mode is not Sleep and the logic supply is valid.
- R8: `wr_ok` equals `spi_ok` except in Limp Home, where it is low, so writes in Limp Home are ignored.
- R9: `ch_avail` is high exactly in Active or Limp Home with the load supply valid.
- R10: Bit i of `src_spi` is high (pins plus SPI) only in Active with both supplies valid. Otherwise it is low (pins only).
- R11: While reset is asserted and after it is released, the mode is Sleep and the wake counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_pin | input | 1 | Wake pin; low requests Sleep or Limp Home |
| in_pins | input | NIN | Direct channel input pins |
| ch_en | input | NCH | Channel enable bits |
| act_bit | input | 1 | Activate bit |
| pwm_en | input | 2 | PWM-generator enable bits |
| vm_uv | input | 1 | Load-supply undervoltage flag |
| vdd_uv | input | 1 | Logic-supply undervoltage flag |
| wake_dly | input | WAKE_W | Wake counter limit |
| mode | output | 2 | Current mode code |
| regs_rst | output | 1 | Register-file reset strobe |
| spi_ok | output | 1 | Serial port enabled |
| wr_ok | output | 1 | Register writes permitted |
| ch_avail | output | 1 | Channels may be switched on |
| src_spi | output | NCH | Per channel: 1 = pins plus SPI, 0 = pins only |

## Verification
Every mode decision takes effect one clock edge after the inputs are sampled. The one exception is a wake-up, where Active arrives `wake_dly`+1 edges after the request appears. The four permission outputs are combinational from the registered mode and the live supply flags, so they settle in the same cycle as the mode. The bench changes inputs just after a rising edge, advances its own arithmetic mode model at the next edge, and compares every output a few nanoseconds after that edge. This lands each comparison on the cycle where the result is due.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_ACTIVE = 2'd2,
        MODE_LIMP   = 2'd3
    } dmc_mode_e;
endpackage

// File: rtl/dmc_req_detect.sv
module dmc_req_detect #(
    parameter int NIN  = 2,
    parameter int NCH  = 8,
    parameter int NPWM = 2
) (
    input  logic [NIN-1:0]  in_pins,
    input  logic [NCH-1:0]  ch_en,
    input  logic            act_bit,
    input  logic [NPWM-1:0] pwm_en,
    output logic            pin_req,
    output logic            any_req
);
    always_comb begin
        pin_req = |in_pins;
        any_req = pin_req | (|ch_en) | act_bit | (|pwm_en);
    end
endmodule

// File: rtl/dmc_wake_timer.sv
module dmc_wake_timer #(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAKE_W-1:0] limit,
    output logic              expired
);
    logic [WAKE_W-1:0] cnt_q;

    always_comb expired = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dmc_out_gate.sv
module dmc_out_gate
    import dmc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  dmc_mode_e       mode_q,
    input  logic            vm_uv,
    input  logic            vdd_uv,
    output logic            regs_rst,
    output logic            spi_ok,
    output logic            wr_ok,
    output logic            ch_avail,
    output logic [NCH-1:0]  src_spi
);
    logic spi_src_ok;

    always_comb begin
        regs_rst   = 1'b0;
        spi_ok     = 1'b0;
        wr_ok      = 1'b0;
        ch_avail   = 1'b0;
        spi_src_ok = 1'b0;
        unique case (mode_q)
            MODE_SLEEP: begin
                regs_rst = 1'b1;
            end
            MODE_IDLE: begin
                regs_rst = vdd_uv;
                spi_ok   = !vdd_uv;
                wr_ok    = !vdd_uv;
            end
            MODE_ACTIVE: begin
                regs_rst   = vdd_uv;
                spi_ok     = !vdd_uv;
                wr_ok      = !vdd_uv;
                ch_avail   = !vm_uv;
                spi_src_ok = !vm_uv && !vdd_uv;
            end
            MODE_LIMP: begin
                regs_rst = vdd_uv;
                spi_ok   = !vdd_uv;
                ch_avail = !vm_uv;
            end
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_src
        assign src_spi[g] = spi_src_ok;
    end
endmodule

// File: rtl/drv_mode_ctrl.sv
module drv_mode_ctrl
    import dmc_pkg::*;
#(
    parameter int NIN    = 2,
    parameter int NCH    = 8,
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_pin,
    input  logic [NIN-1:0]    in_pins,
    input  logic [NCH-1:0]    ch_en,
    input  logic              act_bit,
    input  logic [1:0]        pwm_en,
    input  logic              vm_uv,
    input  logic              vdd_uv,
    input  logic [WAKE_W-1:0] wake_dly,
    output logic [1:0]        mode,
    output logic              regs_rst,
    output logic              spi_ok,
    output logic              wr_ok,
    output logic              ch_avail,
    output logic [NCH-1:0]    src_spi
);
    localparam int NPWM = 2;

    dmc_mode_e state_q, state_d;
    logic      pin_req, any_req, wake_run, wake_done;

    dmc_req_detect #(.NIN(NIN), .NCH(NCH), .NPWM(NPWM)) u_req (
        .in_pins (in_pins),
        .ch_en   (ch_en),
        .act_bit (act_bit),
        .pwm_en  (pwm_en),
        .pin_req (pin_req),
        .any_req (any_req)
    );

    always_comb wake_run = wake_pin && any_req && (state_q != MODE_ACTIVE);

    dmc_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wake_run),
        .limit   (wake_dly),
        .expired (wake_done)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!wake_pin)
            state_d = pin_req ? MODE_LIMP : MODE_SLEEP;   // ENTER_LIMP / FALL_ASLEEP
        else if (!any_req)
            state_d = MODE_IDLE;                          // SETTLE_IDLE
        else begin
            unique case (state_q)
                MODE_ACTIVE: state_d = MODE_ACTIVE;       // STAY_ACTIVE
                MODE_SLEEP,
                MODE_IDLE,
                MODE_LIMP:   state_d = wake_done ? MODE_ACTIVE   // WAKE_DONE
                                                 : MODE_IDLE;    // WAKE_WAIT
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_SLEEP;
        else
            state_q <= state_d;
    end

    dmc_out_gate #(.NCH(NCH)) u_gate (
        .mode_q   (state_q),
        .vm_uv    (vm_uv),
        .vdd_uv   (vdd_uv),
        .regs_rst (regs_rst),
        .spi_ok   (spi_ok),
        .wr_ok    (wr_ok),
        .ch_avail (ch_avail),
        .src_spi  (src_spi)
    );

    assign mode = state_q;
endmodule

// File: rtl/drv_mode_ctrl_chk.sv
module drv_mode_ctrl_chk #(
    parameter int NIN = 2,
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wake_pin,
    input logic [NIN-1:0] in_pins,
    input logic [NCH-1:0] ch_en,
    input logic           act_bit,
    input logic [1:0]     pwm_en,
    input logic           vm_uv,
    input logic           vdd_uv,
    input logic [1:0]     mode,
    input logic           regs_rst,
    input logic           spi_ok,
    input logic           wr_ok,
    input logic           ch_avail,
    input logic [NCH-1:0] src_spi
);
    logic req;
    assign req = (|in_pins) | (|ch_en) | act_bit | (|pwm_en);

    // R1
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_pin && !(|in_pins)) |=> (mode == 2'd0));

    // R2
    limp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_pin && (|in_pins)) |=> (mode == 2'd3));

    // R3
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pin && !req) |=> (mode == 2'd1));

    // R4
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && ($past(mode) != 2'd2)) |-> $past(wake_pin && req));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && wake_pin && req) |=> (mode == 2'd2));

    // R8
    limp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> !wr_ok);

    // R7
    spi_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv |-> (!spi_ok && regs_rst));

    // R9
    load_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vm_uv |-> !ch_avail);

    // R10
    limp_pins_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |-> (src_spi == '0));
endmodule

bind drv_mode_ctrl drv_mode_ctrl_chk #(.NIN(NIN), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_pin (wake_pin),
    .in_pins  (in_pins),
    .ch_en    (ch_en),
    .act_bit  (act_bit),
    .pwm_en   (pwm_en),
    .vm_uv    (vm_uv),
    .vdd_uv   (vdd_uv),
    .mode     (mode),
    .regs_rst (regs_rst),
    .spi_ok   (spi_ok),
    .wr_ok    (wr_ok),
    .ch_avail (ch_avail),
    .src_spi  (src_spi)
);

// File: tb/drv_mode_ctrl_tb.sv
`timescale 1ns/1ps
module drv_mode_ctrl_tb;
    localparam int NIN = 2;
    localparam int NCH = 4;
    localparam int WW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wake_pin = 1'b0;
    logic [NIN-1:0] in_pins = '0;
    logic [NCH-1:0] ch_en = '0;
    logic           act_bit = 1'b0;
    logic [1:0]     pwm_en = '0;
    logic           vm_uv = 1'b0;
    logic           vdd_uv = 1'b0;
    logic [WW-1:0]  wake_dly = '0;
    logic [1:0]     mode;
    logic           regs_rst, spi_ok, wr_ok, ch_avail;
    logic [NCH-1:0] src_spi;

    int n_cmp = 0;
    int n_bad = 0;
    int em = 0;
    int ec = 0;
    string mtag = "R11";
    bit done = 1'b0;

    always #4 clk = ~clk;

    drv_mode_ctrl #(.NIN(NIN), .NCH(NCH), .WAKE_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .in_pins(in_pins),
        .ch_en(ch_en), .act_bit(act_bit), .pwm_en(pwm_en), .vm_uv(vm_uv),
        .vdd_uv(vdd_uv), .wake_dly(wake_dly), .mode(mode), .regs_rst(regs_rst),
        .spi_ok(spi_ok), .wr_ok(wr_ok), .ch_avail(ch_avail), .src_spi(src_spi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int e_rst, e_spi, e_wr, e_av, e_src;
        e_rst = (em == 0 || vdd_uv) ? 1 : 0;
        e_spi = (em != 0 && !vdd_uv) ? 1 : 0;
        e_wr  = (e_spi == 1 && em != 3) ? 1 : 0;
        e_av  = ((em == 2 || em == 3) && !vm_uv) ? 1 : 0;
        e_src = (em == 2 && !vm_uv && !vdd_uv) ? ((1 << NCH) - 1) : 0;
        chk(mtag, int'(mode), em);
        chk("R6 regs_rst", int'(regs_rst), e_rst);
        chk("R7 spi_ok", int'(spi_ok), e_spi);
        chk("R8 wr_ok", int'(wr_ok), e_wr);
        chk("R9 ch_avail", int'(ch_avail), e_av);
        chk("R10 src_spi", int'(src_spi), e_src);
    endtask

    // one clock: update the model at the edge, then compare
    task automatic step();
        bit req;
        req = (|in_pins) || (|ch_en) || act_bit || (|pwm_en);
        @(posedge clk);
        if (!wake_pin) begin
            em = (|in_pins) ? 3 : 0; ec = 0;
            mtag = (|in_pins) ? "R2 mode" : "R1 mode";
        end else if (!req) begin
            em = 1; ec = 0; mtag = "R3 mode";
        end else if (em == 2) begin
            mtag = "R5 mode";
        end else if (ec == int'(wake_dly)) begin
            em = 2; ec = 0; mtag = "R4 mode";
        end else begin
            em = 1; ec++; mtag = "R4 mode";
        end
        #2;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        #10;
        em = 0; mtag = "R11 mode";
        check_all();
        @(posedge clk); #1;
        rst_n = 1'b1;
        #1;
        check_all();

        // R4 directed: wake delay of 3 gives Idle for 3 edges, Active on the 4th
        wake_dly = 4'd3; wake_pin = 1'b1; act_bit = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4 waiting", int'(mode), 1);
        end
        step();
        chk("R4 arrival", int'(mode), 2);
        // R8: Limp Home blocks writes
        wake_pin = 1'b0; in_pins = 2'b01;
        step();
        chk("R8 limp write", int'(wr_ok), 0);

        // near-exhaustive sweep over input combinations and wake limits
        for (int w = 0; w < 3; w++) begin
            wake_dly = (w == 0) ? 4'd0 : (w == 1) ? 4'd1 : 4'd3;
            for (int p = 0; p < 512; p++) begin
                int hold;
                wake_pin = p[0];
                in_pins  = p[2:1];
                ch_en    = p[3] ? NCH'(1 << (p % NCH)) : '0;
                act_bit  = p[4];
                pwm_en   = p[6:5];
                vm_uv    = p[7];
                vdd_uv   = p[8];
                hold = 1 + ((p * 7) >> 2) % 5;
                for (int h = 0; h < hold; h++) step();
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule